// File: doc/BRIEF.md
# Serial NOR Bring-Up Sequencer

This block walks an attached serial NOR flash through its power-on configuration, using a separate command engine that shifts the bytes. When the block leaves reset it runs once by itself. A single-cycle start pulse begins another run whenever the block is idle. Each run has two optional phases. The first enables quad I/O: it reads both status bytes, sets the quad-enable bit that the selected variant calls for, and writes both bytes back. It then reads status until the device reports that it is no longer busy. The second phase switches the device to 4-byte addressing, with an optional write-enable first.

The block talks to the command engine one transaction at a time. It raises a one-cycle request that carries an opcode, a write length, a two-byte write payload and a read flag. The engine replies with a done pulse, an error flag and one read byte. A run ends with `done` held high and an error code beside it. The configuration inputs are captured when the run starts.

Top module: `nor_init_seq`

## Requirements
- R1: When reset is released, one run starts without a start pulse. With both configuration inputs at zero, it issues no transaction and ends with `done`=1 and `err_code`=0.
- R2: A start pulse while idle begins a new run, which clears `done` and then raises it again. A start pulse during a run is ignored: no second run follows.
- R3: If `qe_type`=0, no status read or status write is issued.
- R4: If `qe_type`=1, the transactions are: read 0x05 (one byte), read 0x35 (one byte), write-enable 0x06, and write 0x01 with two bytes. The first status byte is in `txn_wr_data[7:0]` with bit 6 set, the second byte is in `[15:8]`, and all other bits are unchanged.
- R5: If `qe_type` is 2, 3 or 4, the sequence is the same as in R4, but bit 1 of the second status byte is set and the first byte is unchanged.
- R6: If `qe_type` is 5, 6 or 7, both status reads are issued and then the run ends with `err_code`=2, with no write.
- R7: After the status write, opcode 0x05 is re-read until read bit 0 is 0. If `POLL_LIMIT` consecutive reads all show bit 0 set, the run ends with `err_code`=3.
- R8: If `addr4_mode` is nonzero, 0xB7 is issued after any quad phase. If `addr4_mode[1]` is set, 0x06 is issued directly before it.
- R9: A transaction answered with `txn_err`=1 ends the run at once with `err_code`=1, and no further transaction is issued.
- R10: `txn_req` lasts one cycle and is raised only during a run. `done` and `busy` are never high together. A nonzero `err_code` appears only while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, used only when idle |
| qe_type | input | 3 | Quad-enable variant: 0 none, 1 status-1 bit 6, 2..4 status-2 bit 1, 5..7 unsupported |
| addr4_mode | input | 2 | 0 skip; nonzero enter 4-byte addressing; bit 1 adds write-enable before it |
| txn_req | output | 1 | One-cycle transaction request |
| txn_opcode | output | 8 | Command opcode |
| txn_wr_len | output | 2 | Payload bytes to send (0 or 2) |
| txn_wr_data | output | 16 | Payload; byte 0 in [7:0] is sent first |
| txn_rd | output | 1 | Transaction reads one byte back |
| txn_done | input | 1 | Engine completion pulse |
| txn_err | input | 1 | Engine failure flag, valid with `txn_done` |
| txn_rd_data | input | 8 | Byte read, valid with `txn_done` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| err_code | output | 2 | 0 ok, 1 transaction error, 2 unsupported variant, 3 ready-poll timeout |

## Verification
The hardest conditions to reach are the exact edge of the ready-poll budget and a failure in the middle of a run. Both depend on how the attached device behaves, not on the block's own inputs. The bench's device model can be set to stay busy for a chosen number of status reads, so a run that becomes ready on the last allowed read can be compared with one that stays busy one read longer. The model can also fail any chosen transaction by its index. A restart is sent while a run is still in progress, and the bench then confirms that no second run is issued.

// File: rtl/nor_init_pkg.sv
package nor_init_pkg;
  localparam logic [7:0] OP_RDSR1 = 8'h05;
  localparam logic [7:0] OP_RDSR2 = 8'h35;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_EN4B  = 8'hB7;

  localparam logic [2:0] QE_NONE  = 3'd0;
  localparam logic [2:0] QE_S1B6  = 3'd1;
  localparam logic [2:0] QE_S2_LO = 3'd2;
  localparam logic [2:0] QE_S2_HI = 3'd4;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TXN     = 2'd1,
    ERR_UNSUP   = 2'd2,
    ERR_TIMEOUT = 2'd3
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD1, S_RD2, S_CHK, S_WEN_QE, S_WRSR, S_POLL,
    S_A4, S_WEN_A4, S_EN4B, S_FIN
  } st_e;
endpackage

// File: rtl/nor_qe_patch.sv
module nor_qe_patch
  import nor_init_pkg::*;
#(
  parameter int S1_BIT = 6,
  parameter int S2_BIT = 1
) (
  input  logic [2:0] qe_type,
  input  logic [7:0] sr1_in,
  input  logic [7:0] sr2_in,
  output logic [7:0] sr1_out,
  output logic [7:0] sr2_out,
  output logic       unsupported
);
  logic sel_s1, sel_s2;

  always_comb begin
    sel_s1 = (qe_type == QE_S1B6);
    sel_s2 = (qe_type >= QE_S2_LO) && (qe_type <= QE_S2_HI);
    unsupported = (qe_type != QE_NONE) && !sel_s1 && !sel_s2;
    sr1_out = sr1_in;
    sr2_out = sr2_in;
    if (sel_s1) sr1_out[S1_BIT] = 1'b1;
    if (sel_s2) sr2_out[S2_BIT] = 1'b1;
  end
endmodule

// File: rtl/nor_poll_budget.sv
module nor_poll_budget #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));

  // R7: the controller gives up instead of counting past the budget
  a_r7_poll_bound: assert property (@(posedge clk) disable iff (rst)
    inc |-> !last);
endmodule

// File: rtl/nor_init_fsm.sv
module nor_init_fsm
  import nor_init_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [2:0]  qe_type,
  input  logic [1:0]  addr4_mode,
  input  logic        txn_done,
  input  logic        txn_err,
  input  logic [7:0]  txn_rd_data,
  input  logic [7:0]  patched_sr1,
  input  logic [7:0]  patched_sr2,
  input  logic        unsupported,
  input  logic        poll_last,
  output logic [2:0]  qe_q,
  output logic [7:0]  sr1_q,
  output logic [7:0]  sr2_q,
  output logic        poll_clr,
  output logic        poll_inc,
  output logic        txn_req,
  output logic [7:0]  txn_opcode,
  output logic [1:0]  txn_wr_len,
  output logic [15:0] txn_wr_data,
  output logic        txn_rd,
  output logic        busy,
  output logic        done,
  output logic [1:0]  err_code
);
  st_e        state;
  logic       pend, issued;
  logic [1:0] a4_q;
  err_e       err_q;
  logic [7:0] cur_op;
  logic [1:0] cur_wlen;
  logic       cur_rd, is_txn, ok_done;

  always_comb begin
    cur_op = 8'h00; cur_wlen = 2'd0; cur_rd = 1'b0; is_txn = 1'b1;
    case (state)
      S_RD1, S_POLL:      begin cur_op = OP_RDSR1; cur_rd = 1'b1; end
      S_RD2:              begin cur_op = OP_RDSR2; cur_rd = 1'b1; end
      S_WEN_QE, S_WEN_A4: cur_op = OP_WREN;
      S_WRSR:             begin cur_op = OP_WRSR; cur_wlen = 2'd2; end
      S_EN4B:             cur_op = OP_EN4B;
      default:            is_txn = 1'b0;
    endcase
  end

  assign ok_done  = is_txn && issued && txn_done && !txn_err;
  assign poll_clr = (state == S_WRSR);
  assign poll_inc = (state == S_POLL) && ok_done && txn_rd_data[0] && !poll_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; pend <= 1'b1; issued <= 1'b0;
      txn_req <= 1'b0; txn_opcode <= '0; txn_wr_len <= '0;
      txn_wr_data <= '0; txn_rd <= 1'b0;
      busy <= 1'b0; done <= 1'b0; err_code <= '0; err_q <= ERR_NONE;
      qe_q <= '0; a4_q <= '0; sr1_q <= '0; sr2_q <= '0;
    end else begin
      txn_req <= 1'b0;
      if (start && state == S_IDLE) pend <= 1'b1;
      if (is_txn && !issued) begin
        txn_req     <= 1'b1;
        txn_opcode  <= cur_op;
        txn_wr_len  <= cur_wlen;
        txn_rd      <= cur_rd;
        txn_wr_data <= {patched_sr2, patched_sr1};
        issued      <= 1'b1;
      end else if (is_txn && issued && txn_done) begin
        issued <= 1'b0;
        if (txn_err) begin
          err_q <= ERR_TXN; state <= S_FIN;
        end else begin
          case (state)
            S_RD1:    begin sr1_q <= txn_rd_data; state <= S_RD2; end
            S_RD2:    begin sr2_q <= txn_rd_data; state <= S_CHK; end
            S_WEN_QE: state <= S_WRSR;
            S_WRSR:   state <= S_POLL;
            S_POLL: begin
              if (!txn_rd_data[0]) state <= S_A4;
              else if (poll_last) begin err_q <= ERR_TIMEOUT; state <= S_FIN; end
            end
            S_WEN_A4: state <= S_EN4B;
            default:  state <= S_FIN;
          endcase
        end
      end else begin
        case (state)
          S_IDLE: if (pend || (start && !busy)) begin
            pend <= 1'b0; busy <= 1'b1; done <= 1'b0;
            err_code <= '0; err_q <= ERR_NONE;
            qe_q <= qe_type; a4_q <= addr4_mode;
            state <= (qe_type == QE_NONE) ? S_A4 : S_RD1;
          end
          S_CHK: if (unsupported) begin err_q <= ERR_UNSUP; state <= S_FIN; end
                 else state <= S_WEN_QE;
          S_A4: if (a4_q == 2'd0) state <= S_FIN;
                else state <= a4_q[1] ? S_WEN_A4 : S_EN4B;
          S_FIN: begin
            busy <= 1'b0; done <= 1'b1; err_code <= err_q; state <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // R10: requests are single-cycle pulses
  a_r10_req_pulse: assert property (@(posedge clk) disable iff (rst)
    txn_req |=> !txn_req);
  // R10: requests only appear inside a run
  a_r10_req_in_run: assert property (@(posedge clk) disable iff (rst)
    txn_req |-> busy);
  // R10: completion and activity are exclusive
  a_r10_done_busy_excl: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
  // R10: an error code is only presented with done
  a_r10_err_with_done: assert property (@(posedge clk) disable iff (rst)
    (err_code != 2'd0) |-> done);
  // R9: after a failed transaction no new request is raised
  a_r9_stop_on_err: assert property (@(posedge clk) disable iff (rst)
    (issued && txn_done && txn_err) |=> !txn_req);
endmodule

// File: rtl/nor_init_seq.sv
module nor_init_seq
  import nor_init_pkg::*;
#(
  parameter int POLL_LIMIT = 1024,
  parameter int QE_S1_BIT  = 6,
  parameter int QE_S2_BIT  = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [2:0]  qe_type,
  input  logic [1:0]  addr4_mode,
  output logic        txn_req,
  output logic [7:0]  txn_opcode,
  output logic [1:0]  txn_wr_len,
  output logic [15:0] txn_wr_data,
  output logic        txn_rd,
  input  logic        txn_done,
  input  logic        txn_err,
  input  logic [7:0]  txn_rd_data,
  output logic        busy,
  output logic        done,
  output logic [1:0]  err_code
);
  logic [2:0] qe_q;
  logic [7:0] sr1_q, sr2_q, p_sr1, p_sr2;
  logic       unsup, poll_clr, poll_inc, poll_last;

  nor_qe_patch #(.S1_BIT(QE_S1_BIT), .S2_BIT(QE_S2_BIT)) u_patch (
    .qe_type(qe_q), .sr1_in(sr1_q), .sr2_in(sr2_q),
    .sr1_out(p_sr1), .sr2_out(p_sr2), .unsupported(unsup)
  );

  nor_poll_budget #(.LIMIT(POLL_LIMIT)) u_budget (
    .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc), .last(poll_last)
  );

  nor_init_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .qe_type(qe_type),
    .addr4_mode(addr4_mode), .txn_done(txn_done), .txn_err(txn_err),
    .txn_rd_data(txn_rd_data), .patched_sr1(p_sr1), .patched_sr2(p_sr2),
    .unsupported(unsup), .poll_last(poll_last), .qe_q(qe_q),
    .sr1_q(sr1_q), .sr2_q(sr2_q), .poll_clr(poll_clr), .poll_inc(poll_inc),
    .txn_req(txn_req), .txn_opcode(txn_opcode), .txn_wr_len(txn_wr_len),
    .txn_wr_data(txn_wr_data), .txn_rd(txn_rd), .busy(busy), .done(done),
    .err_code(err_code)
  );
endmodule

// File: tb/test_nor_init_seq.sv
module test_nor_init_seq;
  localparam int LIMIT = 4;
  localparam int LAT   = 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] qe_type = 3'd0;
  logic [1:0] addr4_mode = 2'd0;
  logic txn_req, txn_rd, busy, done;
  logic [7:0] txn_opcode;
  logic [1:0] txn_wr_len, err_code;
  logic [15:0] txn_wr_data;
  logic txn_done = 1'b0, txn_err = 1'b0;
  logic [7:0] txn_rd_data = 8'h00;

  int n_chk = 0, n_fail = 0;

  // device model state (owned by the model loop)
  logic [7:0] m_sr1 = 8'h00, m_sr2 = 8'h00, log_op [0:15];
  logic m_wel = 1'b0, m_a4 = 1'b0;
  int m_busy = 0, n_txn = 0;
  // scenario-side preload
  logic [7:0] p_sr1 = 8'h00, p_sr2 = 8'h00;
  int p_wbusy = 0, p_inject = 0;
  logic load_tog = 1'b0, load_seen = 1'b0;

  always #2.5 clk = ~clk;

  nor_init_seq #(.POLL_LIMIT(LIMIT)) i_nor_init_seq (
    .clk(clk), .rst(rst), .start(start), .qe_type(qe_type),
    .addr4_mode(addr4_mode), .txn_req(txn_req), .txn_opcode(txn_opcode),
    .txn_wr_len(txn_wr_len), .txn_wr_data(txn_wr_data), .txn_rd(txn_rd),
    .txn_done(txn_done), .txn_err(txn_err), .txn_rd_data(txn_rd_data),
    .busy(busy), .done(done), .err_code(err_code)
  );

  initial begin : model
    logic [7:0] op;
    logic [15:0] wd;
    forever begin
      @(negedge clk);
      if (load_tog != load_seen) begin
        m_sr1 = p_sr1; m_sr2 = p_sr2; m_wel = 1'b0; m_a4 = 1'b0;
        m_busy = 0; n_txn = 0; load_seen = load_tog;
      end
      if (txn_req) begin
        op = txn_opcode; wd = txn_wr_data;
        if (n_txn < 16) log_op[n_txn] = op;
        n_txn = n_txn + 1;
        repeat (LAT) @(negedge clk);
        txn_rd_data = 8'h00;
        if (n_txn == p_inject) txn_err = 1'b1;
        else begin
          case (op)
            8'h05: begin
              txn_rd_data = {m_sr1[7:1], (m_busy > 0)};
              if (m_busy > 0) m_busy = m_busy - 1;
            end
            8'h35: txn_rd_data = m_sr2;
            8'h06: m_wel = 1'b1;
            8'h01: if (m_wel && txn_wr_len == 2'd2) begin
              m_sr1 = wd[7:0] & 8'hFE; m_sr2 = wd[15:8];
              m_wel = 1'b0; m_busy = p_wbusy;
            end
            8'hB7: m_a4 = 1'b1;
            default: ;
          endcase
        end
        txn_done = 1'b1;
        @(negedge clk);
        txn_done = 1'b0; txn_err = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk = n_chk + 1; n_fail = n_fail + 1;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] s1, input logic [7:0] s2,
                         input int wbusy, input int inj);
    p_sr1 = s1; p_sr2 = s2; p_wbusy = wbusy; p_inject = inj;
    load_tog = ~load_tog;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_done();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
  endtask

  task automatic run(input logic [2:0] qe, input logic [1:0] a4);
    qe_type = qe; addr4_mode = a4;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
  endtask

  task automatic chk_seq(input string req, input logic [63:0] ops, input int n);
    chk(n_txn == n, req, n_txn, n);
    for (int i = 0; i < n && i < n_txn; i++)
      chk(log_op[i] == ops[8*i +: 8], req, log_op[i], ops[8*i +: 8]);
  endtask

  task automatic t_reset_autorun();
    @(negedge clk);
    chk(!txn_req && !done && !busy && err_code == 2'd0, "R10 reset", {txn_req, done, busy}, 0);
    rst = 1'b0;
    wait_done();
    chk(done == 1'b1, "R1 autorun done", done, 1);
    chk(err_code == 2'd0, "R1 autorun err", err_code, 0);
    chk(n_txn == 0, "R1 R3 no traffic", n_txn, 0);
  endtask

  task automatic t_qe_s1();
    preload(8'h1C, 8'h40, 2, 0);
    run(3'd1, 2'd0);
    chk_seq("R4 R7 sequence", 64'h05_05_05_01_06_35_05, 7);
    chk(m_sr1 == 8'h5C && m_sr2 == 8'h40, "R4 status", {m_sr2, m_sr1}, 16'h405C);
    chk(err_code == 2'd0, "R4 err", err_code, 0);
  endtask

  task automatic t_qe_s2();
    preload(8'h1C, 8'h40, 0, 0);
    run(3'd3, 2'd0);
    chk_seq("R5 sequence", 64'h05_01_06_35_05, 5);
    chk(m_sr1 == 8'h1C && m_sr2 == 8'h42, "R5 status", {m_sr2, m_sr1}, 16'h421C);
  endtask

  task automatic t_unsup();
    preload(8'h00, 8'h00, 0, 0);
    run(3'd5, 2'd3);
    chk_seq("R6 sequence", 64'h35_05, 2);
    chk(err_code == 2'd2, "R6 err", err_code, 2);
  endtask

  task automatic t_addr4();
    preload(8'h00, 8'h00, 0, 0);
    run(3'd0, 2'd1);
    chk_seq("R8 plain", 64'hB7, 1);
    chk(m_a4 == 1'b1, "R8 entered", m_a4, 1);
    preload(8'h00, 8'h00, 0, 0);
    run(3'd0, 2'd2);
    chk_seq("R8 with wren", 64'hB7_06, 2);
    preload(8'h00, 8'h00, 0, 0);
    run(3'd2, 2'd3);
    chk_seq("R5 R8 combined", 64'hB7_06_05_01_06_35_05, 7);
    chk(m_sr2 == 8'h02 && m_a4, "R5 R8 state", {m_a4, m_sr2}, 12'h102);
  endtask

  task automatic t_txn_err();
    preload(8'h00, 8'h00, 0, 2);
    run(3'd1, 2'd3);
    chk_seq("R9 stop", 64'h35_05, 2);
    chk(err_code == 2'd1, "R9 err", err_code, 1);
  endtask

  task automatic t_poll_edge();
    preload(8'h00, 8'h00, LIMIT - 1, 0);
    run(3'd1, 2'd0);
    chk(n_txn == 4 + LIMIT && err_code == 2'd0, "R7 last read ready", err_code, 0);
    preload(8'h00, 8'h00, LIMIT, 0);
    run(3'd1, 2'd1);
    chk(n_txn == 4 + LIMIT, "R7 timeout count", n_txn, 4 + LIMIT);
    chk(err_code == 2'd3, "R7 timeout err", err_code, 3);
  endtask

  task automatic t_restart_ignored();
    preload(8'h00, 8'h00, 2, 0);
    qe_type = 3'd1; addr4_mode = 2'd0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R2 running", busy, 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    repeat (40) @(negedge clk);
    chk(n_txn == 7, "R2 restart ignored", n_txn, 7);
    chk(done == 1'b1 && !busy, "R2 settled", {done, busy}, 2);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset_autorun();
    t_qe_s1();
    t_qe_s2();
    t_unsup();
    t_addr4();
    t_txn_err();
    t_poll_edge();
    t_restart_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule